// File: doc/BRIEF.md
# Tagged Split-Transaction Memory Slave

This block is the memory end of a split-transaction bus. A master presents a word address and a direction with a strobe. A few cycles later the slave acknowledges the request and returns a tag that names it. The tag comes from a fixed pool of in-flight slots. Later the slave starts a one-cycle data phase by putting that tag on the call lines. For a read, the word appears on the read-data lines in the next cycle. For a write, the master drives the word and a byte mask in the next cycle, and only the enabled bytes change. Because completion is separate from acceptance, the slave may finish requests in a different order than it took them. A small register-file store stands in for the external memory.

Completion is paced by a three-state scheduler:
- **ST_IDLE**: no request is pending. It moves to **ST_GATHER** when any slot becomes busy.
- **ST_GATHER**: it waits `HOLD` cycles so that requests can build up. It moves to **ST_DRAIN** when that counter expires, or at once when every slot is busy.
- **ST_DRAIN**: it issues one call per cycle while anything is pending. It returns to **ST_IDLE** when no slot is busy.

Each call picks the lowest-numbered pending tag whose direction matches the previous call. When no pending tag matches, it picks the lowest pending tag.

Top module: `tagged_mem_slave`

## Requirements
- R1: After reset, `req_ack` and `call_valid` are low, `rd_data` is zero, and every word of the store reads as zero.
- R2: `req_ack` is a registered response. It is high in a cycle only if `req_stb` was high in the previous cycle. Each acknowledge accepts the request that was on the bus in the previous cycle.
- R3: `req_tag` is valid in the cycle `req_ack` is high. It never names a tag that is still in flight, except a tag that is being called in that same cycle.
- R4: While all `TAGS` tags are in flight, `req_ack` stays low. The one exception is a tag called in the same cycle, which may be handed out again in that cycle.
- R5: At most one call is made per cycle. Every call names a tag that is in flight and frees it. Every accepted request is eventually called.
- R6: For a read, `rd_data` carries the addressed word during exactly the cycle after its call.
- R7: For a write, `wr_data` and `wr_mask` are sampled in the cycle after its call. Only bytes whose mask bit is 1 change. Mask bit b covers data bits 8b+7 to 8b.
- R8: `rd_data` is zero in every cycle that is not a read data phase. This includes the cycle after a write's call.
- R9: Each call picks the lowest-numbered in-flight tag whose direction (`req_we`: 1 means write) equals the direction of the previous call. If none match, it picks the lowest in-flight tag. The direction before the first call counts as read.
- R10: When a request is acknowledged in cycle t and it finds the scheduler in ST_IDLE with no other pending work, its call comes in cycle t+HOLD+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_adr | input | ADDR_W | Word address of the request |
| req_we | input | 1 | Direction of the request: 1 means write |
| req_stb | input | 1 | Request valid; held by the master until acknowledged |
| req_ack | output | 1 | Request accepted; `req_tag` is valid |
| req_tag | output | TAG_W | Tag given to the accepted request |
| call_valid | output | 1 | A data phase follows in the next cycle |
| call_tag | output | TAG_W | Tag of the request being completed |
| rd_data | output | DATA_W | Read word during a read data phase, zero otherwise |
| wr_data | input | DATA_W | Write word during a write data phase |
| wr_mask | input | DATA_W/8 | Byte enables during a write data phase |

## Verification
The bench drives the bus the way a combinational master would: in an acknowledge cycle it drops the old request and offers the next one. A design that sampled the strobe at the wrong point would accept a request twice or lose one. A burst of requests larger than the tag pool fills every slot. A design that acknowledged while full, or that failed to reuse a tag in the same cycle it was called, would give out a duplicate tag or stall for good. Mixed read and write traffic checks every call against the direction-first, lowest-tag rule. Repeated partial-mask writes to a few addresses, each followed by a read, expose byte-lane errors and stale reads. A timed single request from idle catches a gather window that is off by one.

// File: rtl/tms_pkg.sv
package tms_pkg;

    // Scheduler phases
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_DRAIN  = 2'd2
    } sched_st_t;

endpackage

// File: rtl/tms_slots.sv
// In-flight slot table: tag allocation, same-cycle reuse and per-slot request storage.
module tms_slots #(
    parameter int TAGS   = 4,
    parameter int TAG_W  = 2,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_stb,
    input  logic [ADDR_W-1:0]      req_adr,
    input  logic                   req_we,
    input  logic                   rel_vld,
    input  logic [TAG_W-1:0]       rel_tag,
    output logic [TAGS-1:0]        busy,
    output logic [TAGS-1:0]        dir_vec,
    output logic [TAGS*ADDR_W-1:0] adr_flat,
    output logic                   ack,
    output logic [TAG_W-1:0]       tag
);

    logic [TAGS-1:0]   rel_oh;
    logic [TAGS-1:0]   avail;
    logic [TAGS-1:0]   take_oh;
    logic [TAG_W-1:0]  take_idx;
    logic              grant;
    logic [ADDR_W-1:0] slot_adr [TAGS];

    for (genvar i = 0; i < TAGS; i++) begin : g_rel
        assign rel_oh[i] = rel_vld && (rel_tag == TAG_W'(i));
        assign adr_flat[i*ADDR_W +: ADDR_W] = slot_adr[i];
    end

    // A slot being called this cycle may be handed out again at once
    assign avail = ~busy | rel_oh;
    assign grant = req_stb && (|avail);

    always_comb begin
        take_idx = '0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (avail[i]) take_idx = TAG_W'(i);
        end
        take_oh           = '0;
        take_oh[take_idx] = grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= '0;
            ack     <= 1'b0;
            tag     <= '0;
            dir_vec <= '0;
            for (int i = 0; i < TAGS; i++) slot_adr[i] <= '0;
        end else begin
            busy <= (busy & ~rel_oh) | take_oh;
            ack  <= grant;
            if (grant) begin
                tag                <= take_idx;
                slot_adr[take_idx] <= req_adr;
                dir_vec[take_idx]  <= req_we;
            end
        end
    end

endmodule

// File: rtl/tms_sched.sv
// Completion scheduler: gather window, then direction-first draining of pending tags.
module tms_sched
    import tms_pkg::*;
#(
    parameter int TAGS   = 4,
    parameter int TAG_W  = 2,
    parameter int ADDR_W = 6,
    parameter int HOLD   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TAGS-1:0]        busy,
    input  logic [TAGS-1:0]        dir_vec,
    input  logic [TAGS*ADDR_W-1:0] adr_flat,
    output logic                   rel_vld,
    output logic [TAG_W-1:0]       rel_tag,
    output logic                   call_valid,
    output logic [TAG_W-1:0]       call_tag,
    output logic                   call_we,
    output logic [ADDR_W-1:0]      call_adr
);

    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;

    sched_st_t        state, state_n;
    logic [CNT_W-1:0] hold_cnt;
    logic             last_we;
    logic             any_busy;
    logic             all_busy;
    logic [TAGS-1:0]  same_dir;
    logic [TAGS-1:0]  cand;

    assign any_busy = |busy;
    assign all_busy = &busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (any_busy) state_n = ST_GATHER;
            ST_GATHER: if (all_busy || hold_cnt == '0) state_n = ST_DRAIN;
            ST_DRAIN:  if (!any_busy) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Gather window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= CNT_W'(HOLD - 1);
        end else if (state == ST_IDLE) begin
            hold_cnt <= CNT_W'(HOLD - 1);
        end else if (state == ST_GATHER && hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Outputs: pick the next tag to complete
    always_comb begin
        same_dir = busy & (last_we ? dir_vec : ~dir_vec);
        cand     = (|same_dir) ? same_dir : busy;
        rel_tag  = '0;
        for (int i = TAGS - 1; i >= 0; i--) begin
            if (cand[i]) rel_tag = TAG_W'(i);
        end
        rel_vld = (state == ST_DRAIN) && any_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            call_valid <= 1'b0;
            call_tag   <= '0;
            call_we    <= 1'b0;
            call_adr   <= '0;
            last_we    <= 1'b0;
        end else begin
            call_valid <= rel_vld;
            if (rel_vld) begin
                call_tag <= rel_tag;
                call_we  <= dir_vec[rel_tag];
                call_adr <= adr_flat[rel_tag*ADDR_W +: ADDR_W];
                last_we  <= dir_vec[rel_tag];
            end
        end
    end

endmodule

// File: rtl/tms_store.sv
// Word store with a one-cycle data phase after each call.
module tms_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   call_valid,
    input  logic                   call_we,
    input  logic [ADDR_W-1:0]      call_adr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [DATA_W/8-1:0]    wr_mask,
    output logic [DATA_W-1:0]      rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MASK_W = DATA_W / 8;

    logic              dp_vld;
    logic              dp_we;
    logic [ADDR_W-1:0] dp_adr;
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_vld <= 1'b0;
            dp_we  <= 1'b0;
            dp_adr <= '0;
        end else begin
            dp_vld <= call_valid;
            dp_we  <= call_we;
            dp_adr <= call_adr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (dp_vld && dp_we) begin
            for (int b = 0; b < MASK_W; b++) begin
                if (wr_mask[b]) mem[dp_adr][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    assign rd_data = (dp_vld && !dp_we) ? mem[dp_adr] : '0;

endmodule

// File: rtl/tagged_mem_slave.sv
module tagged_mem_slave #(
    parameter int  ADDR_W = 6,
    parameter int  DATA_W = 32,
    parameter int  TAGS   = 4,
    parameter int  HOLD   = 6,
    localparam int TAG_W  = (TAGS > 1) ? $clog2(TAGS) : 1,
    localparam int MASK_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_adr,
    input  logic              req_we,
    input  logic              req_stb,
    output logic              req_ack,
    output logic [TAG_W-1:0]  req_tag,
    output logic              call_valid,
    output logic [TAG_W-1:0]  call_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MASK_W-1:0] wr_mask
);

    logic [TAGS-1:0]        busy;
    logic [TAGS-1:0]        dir_vec;
    logic [TAGS*ADDR_W-1:0] adr_flat;
    logic                   rel_vld;
    logic [TAG_W-1:0]       rel_tag;
    logic                   call_we;
    logic [ADDR_W-1:0]      call_adr;

    tms_slots #(.TAGS(TAGS), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_stb  (req_stb),
        .req_adr  (req_adr),
        .req_we   (req_we),
        .rel_vld  (rel_vld),
        .rel_tag  (rel_tag),
        .busy     (busy),
        .dir_vec  (dir_vec),
        .adr_flat (adr_flat),
        .ack      (req_ack),
        .tag      (req_tag)
    );

    tms_sched #(.TAGS(TAGS), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .HOLD(HOLD)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .dir_vec    (dir_vec),
        .adr_flat   (adr_flat),
        .rel_vld    (rel_vld),
        .rel_tag    (rel_tag),
        .call_valid (call_valid),
        .call_tag   (call_tag),
        .call_we    (call_we),
        .call_adr   (call_adr)
    );

    tms_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_valid (call_valid),
        .call_we    (call_we),
        .call_adr   (call_adr),
        .wr_data    (wr_data),
        .wr_mask    (wr_mask),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/tms_checker.sv
module tms_checker #(
    parameter int TAGS   = 4,
    parameter int TAG_W  = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_stb,
    input logic              req_ack,
    input logic [TAG_W-1:0]  req_tag,
    input logic              call_valid,
    input logic [TAG_W-1:0]  call_tag,
    input logic [DATA_W-1:0] rd_data
);

    // Tags in flight as seen from the ports
    logic [TAGS-1:0] live;
    logic [TAGS-1:0] set_oh;
    logic [TAGS-1:0] clr_oh;

    always_comb begin
        set_oh = '0;
        clr_oh = '0;
        if (req_ack)    set_oh[req_tag]  = 1'b1;
        if (call_valid) clr_oh[call_tag] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= '0;
        else        live <= (live & ~clr_oh) | set_oh;
    end

    assert_ack_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> $past(req_stb));

    assert_tag_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!live[req_tag] || (call_valid && call_tag == req_tag)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((&live) && !call_valid) |-> !req_ack);

    assert_call_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        call_valid |-> live[call_tag]);

    assert_rd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(call_valid) |-> (rd_data == '0));

endmodule

bind tagged_mem_slave tms_checker #(.TAGS(TAGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_tms_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_stb    (req_stb),
    .req_ack    (req_ack),
    .req_tag    (req_tag),
    .call_valid (call_valid),
    .call_tag   (call_tag),
    .rd_data    (rd_data)
);

// File: tb/tagged_mem_slave_bench.sv
module tagged_mem_slave_bench;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int TAGS   = 4;
    localparam int HOLD   = 6;
    localparam int TAG_W  = 2;
    localparam int MASK_W = DATA_W / 8;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int QN     = 256;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n;
    logic              req_ack, call_valid;
    logic [TAG_W-1:0]  req_tag, call_tag;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_data;
    logic [MASK_W-1:0] wr_mask;
    logic              req_stb;

    // Master model
    logic              m_stb;
    logic [ADDR_W-1:0] m_adr;
    logic              m_we;
    logic [DATA_W-1:0] m_dat;
    logic [MASK_W-1:0] m_msk;
    int                load_cyc = -1;
    int                cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // In the acknowledge cycle the old request is withdrawn until the next one is loaded
    assign req_stb = m_stb && !(req_ack && (load_cyc != cyc));

    tagged_mem_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAGS(TAGS), .HOLD(HOLD)) u_tagged_mem_slave (
        .clk(clk), .rst_n(rst_n), .req_adr(m_adr), .req_we(m_we), .req_stb(req_stb),
        .req_ack(req_ack), .req_tag(req_tag), .call_valid(call_valid), .call_tag(call_tag),
        .rd_data(rd_data), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    int n_chk = 0, n_bad = 0;
    logic [DATA_W-1:0] mdl [DEPTH];
    bit                t_busy [TAGS];
    logic [ADDR_W-1:0] t_adr [TAGS];
    bit                t_we [TAGS];
    logic [DATA_W-1:0] t_dat [TAGS];
    logic [MASK_W-1:0] t_msk [TAGS];

    logic [ADDR_W-1:0] q_adr [QN];
    bit                q_we [QN];
    logic [DATA_W-1:0] q_dat [QN];
    logic [MASK_W-1:0] q_msk [QN];
    int q_head = 0, q_tail = 0;

    bit                pv, pwe;
    logic [ADDR_W-1:0] padr;
    logic [DATA_W-1:0] pdat;
    logic [MASK_W-1:0] pmsk;
    bit                last_dir = 1'b0;
    bit                stall_seen = 1'b0;
    int                ack_cyc = 0, call_cyc = 0, n_acks = 0, n_calls = 0;
    logic [DATA_W-1:0] last_rd;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int expect_pick();
        for (int i = 0; i < TAGS; i++)
            if (t_busy[i] && t_we[i] == last_dir) return i;
        for (int i = 0; i < TAGS; i++)
            if (t_busy[i]) return i;
        return -1;
    endfunction

    function automatic int live_count();
        int n = 0;
        for (int i = 0; i < TAGS; i++) n += int'(t_busy[i]);
        return n;
    endfunction

    task automatic push(input logic [ADDR_W-1:0] a, input bit w,
                        input logic [DATA_W-1:0] d, input logic [MASK_W-1:0] k);
        q_adr[q_tail % QN] = a; q_we[q_tail % QN] = w;
        q_dat[q_tail % QN] = d; q_msk[q_tail % QN] = k;
        q_tail++;
    endtask

    task automatic step();
        int cnt;
        @(negedge clk);
        // data phase of the call seen one cycle ago
        if (pv && !pwe) begin
            check(rd_data == mdl[padr], "R6", "read word", rd_data, mdl[padr]);
            last_rd = rd_data;
        end else begin
            check(rd_data == '0, "R8", "idle read bus", rd_data, 0);
        end
        if (pv && pwe) begin
            for (int b = 0; b < MASK_W; b++)       // R7 byte lanes
                if (pmsk[b]) mdl[padr][b*8 +: 8] = pdat[b*8 +: 8];
            wr_data = pdat; wr_mask = pmsk;
        end else begin
            wr_data = '0; wr_mask = '0;
        end
        cnt = live_count();
        pv  = 1'b0;
        if (call_valid) begin
            int e;
            check(t_busy[call_tag], "R5", "called tag in flight", call_tag, 1);
            e = expect_pick();
            check(int'(call_tag) == e, "R9", "call order", call_tag, e);
            pv = 1'b1; pwe = t_we[call_tag]; padr = t_adr[call_tag];
            pdat = t_dat[call_tag]; pmsk = t_msk[call_tag];
            last_dir = t_we[call_tag];
            t_busy[call_tag] = 1'b0;
            call_cyc = cyc; n_calls++;
        end
        if (req_ack) begin
            check(m_stb, "R2", "ack without request", 0, 1);
            check(!t_busy[req_tag], "R3", "issued tag busy", req_tag, 0);
            if (cnt == TAGS)
                check(call_valid && call_tag == req_tag, "R4", "ack while full", req_tag, call_tag);
            t_busy[req_tag] = 1'b1; t_adr[req_tag] = m_adr; t_we[req_tag] = m_we;
            t_dat[req_tag] = m_dat; t_msk[req_tag] = m_msk;
            ack_cyc = cyc; n_acks++;
            m_stb = 1'b0;
        end else if (m_stb && cnt == TAGS) begin
            stall_seen = 1'b1;
        end
        if (!m_stb && q_head != q_tail) begin
            m_adr = q_adr[q_head % QN]; m_we = q_we[q_head % QN];
            m_dat = q_dat[q_head % QN]; m_msk = q_msk[q_head % QN];
            q_head++; m_stb = 1'b1; load_cyc = cyc;
        end
    endtask

    task automatic drain();
        int guard = 0;
        while ((q_head != q_tail || m_stb || live_count() != 0 || pv) && guard < 600) begin
            step(); guard++;
        end
        check(guard < 600, "R5", "all requests completed", guard, 0);
        step();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_9bdf));
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        for (int i = 0; i < TAGS; i++) t_busy[i] = 1'b0;
        m_stb = 1'b0; m_adr = '0; m_we = 1'b0; m_dat = '0; m_msk = '0;
        wr_data = '0; wr_mask = '0; pv = 1'b0; pwe = 1'b0; padr = '0;
        pdat = '0; pmsk = '0; last_rd = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ack == 1'b0, "R1", "ack after reset", req_ack, 0);
        check(call_valid == 1'b0, "R1", "call after reset", call_valid, 0);
        check(rd_data == '0, "R1", "read bus after reset", rd_data, 0);

        // R1: untouched word reads zero; R10: timing from idle
        push(6'd5, 1'b0, '0, '0);
        begin
            int a0 = n_acks, c0 = n_calls;
            while (n_acks == a0) step();
            while (n_calls == c0) step();
            check(call_cyc - ack_cyc == HOLD + 2, "R10", "gather latency",
                  call_cyc - ack_cyc, HOLD + 2);
        end
        drain();
        check(last_rd == '0, "R1", "store cleared", last_rd, 0);

        // R7: masked byte writes
        push(6'd9, 1'b1, 32'hAABBCCDD, 4'hF);
        drain();
        push(6'd9, 1'b1, 32'h11223344, 4'b0101);
        drain();
        push(6'd9, 1'b0, '0, '0);
        drain();
        check(last_rd == 32'hAA22CC44, "R7", "masked merge", last_rd, 32'hAA22CC44);

        // R4: more requests than tags, mixed directions (R9 checked per call)
        for (int i = 0; i < TAGS + 3; i++)
            push(ADDR_W'(i), (i % 3) == 1, 32'h0101_0101 * (i + 1), 4'hF);
        drain();
        check(stall_seen, "R4", "full pool stalled the master", stall_seen, 1);

        // random mixed traffic
        for (int i = 0; i < 4000; i++) begin
            if ((q_tail - q_head) < 4 && ($urandom % 2) == 0)
                push(ADDR_W'($urandom % 12), ($urandom % 2) == 1, $urandom,
                     MASK_W'($urandom % 16));
            step();
        end
        drain();
        check(live_count() == 0, "R5", "nothing left in flight", live_count(), 0);

        summary();
        $finish;
    end

endmodule